// File: doc/BRIEF.md
# Sequential-Read Serial Memory Slave

This block is the device side of a small serial memory that answers one command: a streaming read. It watches chip select, the serial clock and the serial data input through a synchronizer running on the system clock. An 8-bit instruction is shifted in first, and one of its bits carries the ninth address bit. An 8-bit address follows. The block then returns bytes from an internal register file, most significant bit first.

While chip select stays low, the address advances by one after every byte. At the top of the array it returns to zero, so a single command can sweep the whole array any number of times. Releasing chip select ends the command at any bit. The data output then stops driving, and the next low phase of chip select starts a new decode.

A write-busy input from neighbouring logic refuses the command. A size parameter selects a 256-byte or a 512-byte array. A preload port fills the register file from the system side.

Top module: `spi_seqrd_mem`

## Requirements
- R1: The data output enable `miso_oe` is low after reset and during the instruction and address phases. It goes low again within SYNC_STAGES+2 clock cycles after `cs_n` goes high. Low `miso_oe` means the pad is high-impedance.
- R2: The instruction is accepted only when `(byte & 8'hF7) == 8'h03`. Bit 3 is excluded from the compare. Any other instruction, for example 8'h02 or 8'h83, leaves `miso_oe` low until `cs_n` rises.
- R3: In the 512-byte configuration the start address is {instruction bit 3, address byte}. All bytes arrive MSB first, and each bit is sampled on the rising serial clock.
- R4: Bit 7 of the first data byte is driven on the falling serial clock edge that follows the eighth address bit. The following bits go out MSB first, one per falling edge, and `miso_o` changes on no other edge.
- R5: While `cs_n` stays low, the address increments by one after each byte, and the next byte's bit 7 follows the previous byte's bit 0 with no idle clock.
- R6: Past the highest address (0x1FF for 512 bytes, 0xFF for 256 bytes), the address wraps to 0.
- R7: A rise of `cs_n` in the middle of a byte abandons the command. The next low phase decodes a fresh instruction.
- R8: If `wr_busy` is high when the eighth instruction bit is sampled, the command is refused and `miso_oe` stays low.
- R9: With MEM_BYTES = 256, instruction bit 3 is ignored and the start address is the address byte alone.
- R10: A clock cycle with `pre_we` high writes `pre_data` to array location `pre_addr`, and later reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock (mode 0) |
| mosi | input | 1 | Serial data into the device |
| wr_busy | input | 1 | High while a write cycle is in progress |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | log2(MEM_BYTES) | Preload byte address |
| pre_data | input | 8 | Preload byte |
| miso_o | output | 1 | Serial data out of the device |
| miso_oe | output | 1 | Output enable for the data pad; low means high-impedance |

## Verification
Two instances run side by side on the same serial stimulus: one sized for 512 bytes and one for 256 bytes. Instructions 8'h03 and 8'h0B read the same address byte, and the two sizes are expected to return different locations. This separates correct use of the ninth address bit from ignoring it. Start addresses near each top boundary separate true wrap-around from running past the end. A 40-byte stream exposes any gap or skipped byte between bytes. Rejected opcodes, a busy refusal and a mid-byte abort followed by a fresh read show that the output stays quiet when it should and that the decoder restarts cleanly.

// File: rtl/spi_seqrd_pkg.sv
`timescale 1ns/1ps
package spi_seqrd_pkg;
   typedef enum logic [1:0] {
      ST_OPC  = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_SKIP = 2'd3
   } rd_state_t;

   localparam logic [7:0] RD_OPC_MASK = 8'hF7;
   localparam logic [7:0] RD_OPC_VAL  = 8'h03;
   localparam int unsigned HI_ADDR_POS = 3;
endpackage

// File: rtl/spi_seqrd_sync.sv
`timescale 1ns/1ps
module spi_seqrd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sck_i,
   input  logic mosi_i,
   output logic cs_act_o,
   output logic sck_rise_o,
   output logic sck_fall_o,
   output logic mosi_o
);
   localparam int unsigned PW = 3;
   localparam logic [PW-1:0] IDLE_VEC = 3'b001;

   logic [PW-1:0] pipe [STAGES];
   logic          sck_q;
   logic [PW-1:0] tail;

   if (STAGES < 1) begin : g_bad_stages
      $error("spi_seqrd_sync: STAGES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= IDLE_VEC;
         sck_q <= 1'b0;
      end else begin
         pipe[0] <= {mosi_i, sck_i, cs_n_i};
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
         sck_q <= tail[1];
      end
   end

   assign tail       = pipe[STAGES-1];
   assign cs_act_o   = ~tail[0];
   assign sck_rise_o = tail[1] & ~sck_q;
   assign sck_fall_o = ~tail[1] & sck_q;
   assign mosi_o     = tail[2];
endmodule

// File: rtl/spi_seqrd_array.sv
`timescale 1ns/1ps
module spi_seqrd_array #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/spi_seqrd_ctrl.sv
`timescale 1ns/1ps
module spi_seqrd_ctrl
   import spi_seqrd_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 512,
   localparam int unsigned AW       = $clog2(MEM_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_act,
   input  logic            sck_rise,
   input  logic            sck_fall,
   input  logic            mosi_s,
   input  logic            wr_busy,
   input  logic [7:0]      rd_data,
   output logic [AW-1:0]   addr_o,
   output rd_state_t       state_o,
   output logic [2:0]      bit_cnt_o,
   output logic            miso_o,
   output logic            miso_oe
);
   rd_state_t     state;
   logic [2:0]    bit_cnt;
   logic [6:0]    shreg;
   logic [7:0]    shift_nxt;
   logic [AW-1:0] addr;
   logic [AW-1:0] start_addr;
   logic [2:0]    bidx;
   logic          miso_q;
   logic          oe_q;
   logic          last_bit;
   logic          opc_match;
   logic          opc_accept;

   assign shift_nxt  = {shreg, mosi_s};
   assign last_bit   = sck_rise && (bit_cnt == 3'd7);
   assign opc_match  = (shift_nxt & RD_OPC_MASK) == RD_OPC_VAL;
   assign opc_accept = cs_act && (state == ST_OPC) && last_bit && opc_match && !wr_busy;

   if (MEM_BYTES == 512) begin : g_addr9
      logic hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          hi_q <= 1'b0;
         else if (opc_accept) hi_q <= shift_nxt[HI_ADDR_POS];
      end
      assign start_addr = {hi_q, shift_nxt};
   end else begin : g_addr8
      assign start_addr = shift_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_OPC;
         bit_cnt <= '0;
         shreg   <= '0;
         addr    <= '0;
         bidx    <= 3'd7;
         miso_q  <= 1'b0;
         oe_q    <= 1'b0;
      end else if (!cs_act) begin
         state   <= ST_OPC;
         bit_cnt <= '0;
         oe_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_OPC: begin
               if (sck_rise) begin
                  shreg   <= shift_nxt[6:0];
                  bit_cnt <= bit_cnt + 3'd1;
                  if (last_bit) state <= opc_accept ? ST_ADDR : ST_SKIP;
               end
            end
            ST_ADDR: begin
               if (sck_rise) begin
                  shreg   <= shift_nxt[6:0];
                  bit_cnt <= bit_cnt + 3'd1;
                  if (last_bit) begin
                     addr  <= start_addr;
                     bidx  <= 3'd7;
                     state <= ST_DATA;
                  end
               end
            end
            ST_DATA: begin
               if (sck_fall) begin
                  miso_q <= rd_data[bidx];
                  oe_q   <= 1'b1;
                  bidx   <= bidx - 3'd1;
                  if (bidx == 3'd0) addr <= addr + 1'b1;
               end
            end
            ST_SKIP: ;
            default: state <= ST_OPC;
         endcase
      end
   end

   assign addr_o    = addr;
   assign state_o   = state;
   assign bit_cnt_o = bit_cnt;
   assign miso_o    = miso_q;
   assign miso_oe   = oe_q;
endmodule

// File: rtl/spi_seqrd_mem.sv
`timescale 1ns/1ps
module spi_seqrd_mem
   import spi_seqrd_pkg::*;
#(
   parameter int unsigned MEM_BYTES   = 512,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW         = $clog2(MEM_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          sck,
   input  logic          mosi,
   input  logic          wr_busy,
   input  logic          pre_we,
   input  logic [AW-1:0] pre_addr,
   input  logic [7:0]    pre_data,
   output logic          miso_o,
   output logic          miso_oe
);
   if (MEM_BYTES != 256 && MEM_BYTES != 512) begin : g_bad_size
      $error("spi_seqrd_mem: MEM_BYTES must be 256 or 512");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("spi_seqrd_mem: SYNC_STAGES must be at least 1");
   end

   logic          cs_act_w;
   logic          sck_rise_w;
   logic          sck_fall_w;
   logic          mosi_w;
   logic [AW-1:0] addr_w;
   logic [7:0]    rd_data_w;
   rd_state_t     st_w;
   logic [2:0]    bit_cnt_w;

   spi_seqrd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_i     (cs_n),
      .sck_i      (sck),
      .mosi_i     (mosi),
      .cs_act_o   (cs_act_w),
      .sck_rise_o (sck_rise_w),
      .sck_fall_o (sck_fall_w),
      .mosi_o     (mosi_w)
   );

   spi_seqrd_array #(.DEPTH(MEM_BYTES), .DW(8)) u_array (
      .clk     (clk),
      .wr_en   (pre_we),
      .wr_addr (pre_addr),
      .wr_data (pre_data),
      .rd_addr (addr_w),
      .rd_data (rd_data_w)
   );

   spi_seqrd_ctrl #(.MEM_BYTES(MEM_BYTES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act_w),
      .sck_rise  (sck_rise_w),
      .sck_fall  (sck_fall_w),
      .mosi_s    (mosi_w),
      .wr_busy   (wr_busy),
      .rd_data   (rd_data_w),
      .addr_o    (addr_w),
      .state_o   (st_w),
      .bit_cnt_o (bit_cnt_w),
      .miso_o    (miso_o),
      .miso_oe   (miso_oe)
   );
endmodule

// File: rtl/spi_seqrd_chk.sv
`timescale 1ns/1ps
module spi_seqrd_chk
   import spi_seqrd_pkg::*;
#(
   parameter int unsigned AW          = 9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          wr_busy,
   input logic          miso_o,
   input logic          miso_oe,
   input rd_state_t     st,
   input logic [2:0]    bit_cnt,
   input logic [AW-1:0] addr,
   input logic          sck_rise,
   input logic          sck_fall,
   input logic          cs_act
);
   localparam int unsigned QUIET_LIM = SYNC_STAGES + 2;
   localparam int unsigned CW        = $clog2(QUIET_LIM + 1);

   logic [CW-1:0] high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           high_cnt <= '0;
      else if (!cs_n)                       high_cnt <= '0;
      else if (high_cnt != CW'(QUIET_LIM))  high_cnt <= high_cnt + 1'b1;
   end

   assert_quiet_after_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (high_cnt == CW'(QUIET_LIM)) |-> !miso_oe);

   assert_drive_only_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> (st == ST_DATA));

   assert_change_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_fall |=> $stable(miso_o));

   assert_skip_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP && cs_act) |=> (st == ST_SKIP));

   assert_busy_refuses_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OPC && cs_act && sck_rise && bit_cnt == 3'd7 && wr_busy) |=> (st == ST_SKIP));

   assert_addr_steps_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && $past(st) == ST_DATA) |->
         (addr == $past(addr) || addr == AW'($past(addr) + 1'b1)));
endmodule

bind spi_seqrd_mem spi_seqrd_chk #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .wr_busy  (wr_busy),
   .miso_o   (miso_o),
   .miso_oe  (miso_oe),
   .st       (st_w),
   .bit_cnt  (bit_cnt_w),
   .addr     (addr_w),
   .sck_rise (sck_rise_w),
   .sck_fall (sck_fall_w),
   .cs_act   (cs_act_w)
);

// File: tb/spi_seqrd_mem_tb_top.sv
`timescale 1ns/1ps
module spi_seqrd_mem_tb_top;
   localparam int HP = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sck = 1'b0;
   logic       mosi = 1'b0;
   logic       wr_busy = 1'b0;
   logic       pre_we = 1'b0;
   logic [8:0] pre_addr = '0;
   logic [7:0] pre_data = '0;
   logic       miso_l, oe_l, miso_s, oe_s;

   int vectors = 0;
   int miscompares = 0;
   logic [7:0] ref_l [512];
   logic [7:0] ref_s [256];

   spi_seqrd_mem #(.MEM_BYTES(512)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .wr_busy(wr_busy), .pre_we(pre_we), .pre_addr(pre_addr),
      .pre_data(pre_data), .miso_o(miso_l), .miso_oe(oe_l));

   spi_seqrd_mem #(.MEM_BYTES(256)) dut_s_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .wr_busy(wr_busy), .pre_we(pre_we), .pre_addr(pre_addr[7:0]),
      .pre_data(pre_data), .miso_o(miso_s), .miso_oe(oe_s));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic preload(input int a, input logic [7:0] d);
      @(negedge clk);
      pre_we = 1'b1; pre_addr = 9'(a); pre_data = d;
      @(negedge clk);
      pre_we = 1'b0;
      ref_l[a % 512] = d;
      ref_s[a % 256] = d;
   endtask

   // Reference model: accepted when (op & F7) == 03 and not busy; the large
   // array starts at {op[3], ad}, the small one at ad; bit 7 of the first byte
   // is sampled at the 17th rising edge, bytes follow back to back with wrap.
   task automatic spi_read(input string req, input logic [7:0] op, input logic [7:0] ad,
                           input int nbytes, input int extra_bits, input logic busy);
      int total;
      logic [15:0] hdr;
      logic ok;
      int st_l, st_s;
      total = 16 + nbytes * 8 + extra_bits;
      hdr = {op, ad};
      ok = ((op & 8'hF7) == 8'h03) && !busy;
      st_l = int'({op[3], ad});
      st_s = int'(ad);
      wr_busy = busy;
      cs_n = 1'b0;
      tick(HP);
      for (int k = 0; k < total; k++) begin
         mosi = (k < 16) ? hdr[15 - k] : 1'b0;
         tick(HP);
         if (ok && k >= 16) begin
            int d, bi, off;
            d = k - 16; bi = 7 - (d % 8); off = d / 8;
            check(req, "oe512", oe_l, 1'b1);
            check(req, "data512", miso_l, ref_l[(st_l + off) % 512][bi]);
            check(req, "oe256", oe_s, 1'b1);
            check(req, "data256", miso_s, ref_s[(st_s + off) % 256][bi]);
         end else begin
            check(req, "oe512 quiet", oe_l, 1'b0);
            check(req, "oe256 quiet", oe_s, 1'b0);
         end
         sck = 1'b1;
         tick(HP);
         sck = 1'b0;
      end
      tick(HP);
      cs_n = 1'b1;
      tick(2 * HP);
      check("R1/R7", "oe512 after release", oe_l, 1'b0);
      check("R1/R7", "oe256 after release", oe_s, 1'b0);
      wr_busy = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      tick(5);
      check("R1", "oe512 in reset", oe_l, 1'b0);
      check("R1", "oe256 in reset", oe_s, 1'b0);
      rst_n = 1'b1;
      tick(3);
      check("R1", "oe512 after reset", oe_l, 1'b0);
      check("R1", "oe256 after reset", oe_s, 1'b0);

      // R10: fill both arrays through the preload port
      for (int i = 0; i < 512; i++) preload(i, 8'((i * 37 + 11) & 255));

      spi_read("R3/R4", 8'h03, 8'h05, 3, 0, 1'b0);
      spi_read("R3/R9", 8'h0B, 8'hF0, 2, 0, 1'b0);
      spi_read("R6",    8'h0B, 8'hFE, 4, 0, 1'b0);
      spi_read("R6/R9", 8'h03, 8'hFF, 2, 0, 1'b0);
      spi_read("R5",    8'h03, 8'h00, 40, 0, 1'b0);
      spi_read("R2",    8'h02, 8'h00, 2, 0, 1'b0);
      spi_read("R2",    8'h83, 8'h10, 2, 0, 1'b0);
      spi_read("R8",    8'h03, 8'h20, 2, 0, 1'b1);
      spi_read("R7",    8'h0B, 8'h40, 0, 3, 1'b0);
      spi_read("R7",    8'h03, 8'h41, 1, 0, 1'b0);

      preload(9'h123, 8'hA5);
      preload(9'h023, 8'h5A);
      spi_read("R10",   8'h0B, 8'h23, 1, 0, 1'b0);
      spi_read("R10",   8'h03, 8'h23, 1, 0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule